// File: doc/BRIEF.md
# PLL Multiplier/Divider Search Engine

This block picks the settings of a frequency synthesizer for a requested output. Given a reference frequency and a target frequency, both integers in hertz, it steps through every combination of a feedback multiplier, a one-bit pre-divider and a power-of-two post-divider shift. It keeps the setting whose output comes closest to the target without going above it. Once the search ends it also derives a loop-filter range code from the frequency seen after the pre-divider, and packs all fields into one configuration word that can be written to the synthesizer.

A search starts with a one-cycle `start` pulse while the engine is idle. The engine tests one candidate per clock, stops early at the first exact hit, and then raises `done` for one cycle. The result outputs keep their values until the next search finishes. When no candidate lies at or below the target, a no-match flag is raised and every field is cleared.

Top module: `pll_param_search`

## Requirements
- R1: A candidate's output frequency is floor(ref × (mul+1) / ((div1+1) × 2^div2)), with mul in 0..255, div1 in 0..1 and div2 in 0..7; `achievedHz` reports this value for the chosen setting.
- R2: A candidate whose frequency is greater than the target is never chosen, so `achievedHz` never exceeds the target.
- R3: The candidates are visited with div1 outermost (1 then 0), div2 in the middle (7 down to 0) and mul innermost (0 up to 255). The chosen setting has the smallest error (target − frequency), and among equal errors the one visited first wins.
- R4: The first candidate whose frequency equals the target ends the search and sets `exact`; otherwise `exact` is 0.
- R5: Let f = floor(floor(ref / 1,000,000) / (div1+1)), using the chosen div1. The filter code is 7 when f ≥ 166, 6 when f ≥ 104, 5 when f ≥ 65, 4 when f ≥ 42, 3 when f ≥ 26, 2 when f ≥ 16, 1 when f ≥ 10, and 0 otherwise.
- R6: `cfgWord` carries the filter code in bits 26:24, mul in bits 23:16, div1 in bit 8 and div2 in bits 2:0. All other bits are 0.
- R7: When no candidate is at or below the target, `noMatch` is 1, and mul, div1, div2, the filter code, `achievedHz`, `exact` and `cfgWord` are all 0.
- R8: `done` is high for exactly one cycle per search, and `busy` is low while it is high. The result outputs change only in the cycle `done` rises and hold between searches.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running search finishes with its original operands, and no extra search follows.
- R10: During and right after reset, `busy`, `done`, `exact`, `noMatch`, all fields and `cfgWord` are 0.
- R11: One candidate is tested per clock. After the clock edge that accepts `start`, `done` is visible N+1 cycles later, where N is the number of candidates tested. A search never tests more than 4096 candidates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; sampled only when idle |
| refHz | input | 32 | Reference frequency in Hz |
| targetHz | input | 40 | Target output frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| mulOut | output | 8 | Chosen multiplier field |
| div1Out | output | 1 | Chosen pre-divider field |
| div2Out | output | 3 | Chosen post-divider shift |
| filtOut | output | 3 | Loop-filter range code |
| achievedHz | output | 40 | Output frequency of the chosen setting |
| exact | output | 1 | Chosen setting hits the target exactly |
| noMatch | output | 1 | No candidate at or below the target |
| cfgWord | output | 32 | Packed configuration word |

## Verification
An exact hit and the natural end of the ordering can fall on the same cycle. The bench provokes this with a target equal to ref × 256: no candidate before the very last one (div1 = 0, div2 = 0, mul = 255) can reach that value, so the final step is both the exact-hit stop and the end of the ordering. The result is judged against an independent model of the ordered search, which must report an exact setting of mul 255 with both dividers at zero. The cycle count must also be 4097, which shows the stop was taken exactly once and on the last candidate.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

  // Strobes from the sequencer to the search datapath
  typedef struct packed {
    logic init;    // load operands, clear best, rewind counters
    logic step;    // evaluate current candidate and advance
    logic finish;  // publish results to the outputs
  } srchCtrl_t;

  // Status from the datapath back to the sequencer
  typedef struct packed {
    logic stop;    // current candidate is the last one to test
  } srchStat_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } srchState_t;

  localparam int unsigned FILT_LEVELS = 7;
  localparam int unsigned FILT_W      = 3;
  localparam longint unsigned MHZ_HZ  = 64'd1_000_000;

  // Filter band lower edges in MHz, lowest band first
  function automatic int unsigned filtEdgeMhz(input int unsigned idx);
    case (idx)
      0:       return 10;
      1:       return 16;
      2:       return 26;
      3:       return 42;
      4:       return 65;
      5:       return 104;
      default: return 166;
    endcase
  endfunction

endpackage

// File: rtl/pllsrch_ctrl.sv
module pllsrch_ctrl
  import pllsrch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  srchStat_t stat,
  output srchCtrl_t ctrl,
  output logic      busy,
  output logic      done
);

  srchState_t state, stateNext;
  logic       doneQ;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctrl.init = 1'b1;
          stateNext = S_RUN;
        end
      end
      S_RUN: begin
        ctrl.step = 1'b1;
        if (stat.stop) stateNext = S_FIN;
      end
      S_FIN: begin
        ctrl.finish = 1'b1;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= (state == S_FIN);
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/pllsrch_dp.sv
module pllsrch_dp
  import pllsrch_pkg::*;
#(
  parameter int unsigned REF_W  = 32,
  parameter int unsigned MUL_W  = 8,
  parameter int unsigned DIV2_W = 3,
  parameter int unsigned CFG_W  = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  srchCtrl_t                      ctrl,
  input  logic [REF_W-1:0]               refHz,
  input  logic [REF_W+MUL_W-1:0]         targetHz,
  output srchStat_t                      stat,
  output logic [MUL_W-1:0]               mulOut,
  output logic                           div1Out,
  output logic [DIV2_W-1:0]              div2Out,
  output logic [FILT_W-1:0]              filtOut,
  output logic [REF_W+MUL_W-1:0]         achievedHz,
  output logic                           exact,
  output logic                           noMatch,
  output logic [CFG_W-1:0]               cfgWord
);

  localparam int unsigned TGT_W    = REF_W + MUL_W;
  localparam int unsigned SHIFT_W  = DIV2_W + 1;
  localparam int unsigned DIV2_LSB = 0;
  localparam int unsigned DIV1_POS = 8;
  localparam int unsigned MUL_LSB  = 16;
  localparam int unsigned FILT_LSB = MUL_LSB + MUL_W;

  // Operands captured at start
  logic [REF_W-1:0]  refQ;
  logic [TGT_W-1:0]  tgtQ;

  // Search position
  logic [MUL_W-1:0]  mulCnt;
  logic [DIV2_W-1:0] div2Cnt;
  logic              div1Cnt;

  // Best candidate so far
  logic              haveBest;
  logic [TGT_W-1:0]  bestErr;
  logic [TGT_W-1:0]  bestCand;
  logic [MUL_W-1:0]  bestMul;
  logic              bestDiv1;
  logic [DIV2_W-1:0] bestDiv2;

  // Candidate evaluation: the total divisor is always a power of two
  logic [TGT_W-1:0]   prod, cand, err;
  logic [SHIFT_W-1:0] shiftAmt;
  logic               over, better, exactHit, lastRow, rowEnd;

  always_comb begin
    prod     = TGT_W'(refQ) * (TGT_W'(mulCnt) + TGT_W'(1));
    shiftAmt = SHIFT_W'(div2Cnt) + SHIFT_W'(div1Cnt);
    cand     = prod >> shiftAmt;
    over     = cand > tgtQ;
    err      = tgtQ - cand;
    better   = !over && (!haveBest || (err < bestErr));
    exactHit = !over && (err == '0);
    lastRow  = !div1Cnt && (div2Cnt == '0);
    // A row ends at its last multiplier, or once the output passes the target
    // (it only grows with mul, so nothing later in the row can qualify)
    rowEnd   = over || (mulCnt == '1);
    stat.stop = exactHit || (rowEnd && lastRow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refQ     <= '0;
      tgtQ     <= '0;
      mulCnt   <= '0;
      div2Cnt  <= '0;
      div1Cnt  <= 1'b0;
      haveBest <= 1'b0;
      bestErr  <= '0;
      bestCand <= '0;
      bestMul  <= '0;
      bestDiv1 <= 1'b0;
      bestDiv2 <= '0;
    end else if (ctrl.init) begin
      refQ     <= refHz;
      tgtQ     <= targetHz;
      mulCnt   <= '0;
      div2Cnt  <= '1;
      div1Cnt  <= 1'b1;
      haveBest <= 1'b0;
      bestErr  <= '0;
      bestCand <= '0;
      bestMul  <= '0;
      bestDiv1 <= 1'b0;
      bestDiv2 <= '0;
    end else if (ctrl.step) begin
      if (rowEnd) begin
        mulCnt <= '0;
        if (div2Cnt == '0) begin
          div2Cnt <= '1;
          div1Cnt <= 1'b0;
        end else begin
          div2Cnt <= div2Cnt - 1'b1;
        end
      end else begin
        mulCnt <= mulCnt + 1'b1;
      end
      if (better) begin
        haveBest <= 1'b1;
        bestErr  <= err;
        bestCand <= cand;
        bestMul  <= mulCnt;
        bestDiv1 <= div1Cnt;
        bestDiv2 <= div2Cnt;
      end
    end
  end

  // Filter band: compare the reference against each band edge scaled by the
  // pre-divider, in Hz, and count the edges reached
  logic [FILT_LEVELS-1:0] filtHit;
  logic [FILT_W-1:0]      filtCode;

  for (genvar i = 0; i < FILT_LEVELS; i++) begin : g_filt
    localparam logic [63:0] EDGE_HZ = 64'(filtEdgeMhz(i)) * MHZ_HZ;
    assign filtHit[i] = 64'(refQ) >= (bestDiv1 ? (EDGE_HZ << 1) : EDGE_HZ);
  end

  always_comb begin
    filtCode = '0;
    for (int k = 0; k < FILT_LEVELS; k++) filtCode = filtCode + FILT_W'(filtHit[k]);
  end

  logic [CFG_W-1:0] cfgNext;
  always_comb begin
    cfgNext = '0;
    cfgNext[FILT_LSB +: FILT_W]  = filtCode;
    cfgNext[MUL_LSB +: MUL_W]    = bestMul;
    cfgNext[DIV1_POS]            = bestDiv1;
    cfgNext[DIV2_LSB +: DIV2_W]  = bestDiv2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mulOut     <= '0;
      div1Out    <= 1'b0;
      div2Out    <= '0;
      filtOut    <= '0;
      achievedHz <= '0;
      exact      <= 1'b0;
      noMatch    <= 1'b0;
      cfgWord    <= '0;
    end else if (ctrl.finish) begin
      if (haveBest) begin
        mulOut     <= bestMul;
        div1Out    <= bestDiv1;
        div2Out    <= bestDiv2;
        filtOut    <= filtCode;
        achievedHz <= bestCand;
        exact      <= (bestErr == '0);
        noMatch    <= 1'b0;
        cfgWord    <= cfgNext;
      end else begin
        mulOut     <= '0;
        div1Out    <= 1'b0;
        div2Out    <= '0;
        filtOut    <= '0;
        achievedHz <= '0;
        exact      <= 1'b0;
        noMatch    <= 1'b1;
        cfgWord    <= '0;
      end
    end
  end

endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
  import pllsrch_pkg::*;
#(
  parameter int unsigned REF_W  = 32,
  parameter int unsigned MUL_W  = 8,
  parameter int unsigned DIV2_W = 3,
  parameter int unsigned CFG_W  = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [REF_W-1:0]       refHz,
  input  logic [REF_W+MUL_W-1:0] targetHz,
  output logic                   busy,
  output logic                   done,
  output logic [MUL_W-1:0]       mulOut,
  output logic                   div1Out,
  output logic [DIV2_W-1:0]      div2Out,
  output logic [FILT_W-1:0]      filtOut,
  output logic [REF_W+MUL_W-1:0] achievedHz,
  output logic                   exact,
  output logic                   noMatch,
  output logic [CFG_W-1:0]       cfgWord
);

  srchCtrl_t ctrl;
  srchStat_t stat;

  pllsrch_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  pllsrch_dp #(
    .REF_W  (REF_W),
    .MUL_W  (MUL_W),
    .DIV2_W (DIV2_W),
    .CFG_W  (CFG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .refHz      (refHz),
    .targetHz   (targetHz),
    .stat       (stat),
    .mulOut     (mulOut),
    .div1Out    (div1Out),
    .div2Out    (div2Out),
    .filtOut    (filtOut),
    .achievedHz (achievedHz),
    .exact      (exact),
    .noMatch    (noMatch),
    .cfgWord    (cfgWord)
  );

endmodule

// File: rtl/pllsrch_chk.sv
module pllsrch_chk #(
  parameter int unsigned REF_W = 32,
  parameter int unsigned MUL_W = 8,
  parameter int unsigned CFG_W = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic [REF_W+MUL_W-1:0] targetHz,
  input logic [REF_W+MUL_W-1:0] achievedHz,
  input logic                   exact,
  input logic                   noMatch,
  input logic [CFG_W-1:0]       cfgWord
);

  // Target of the accepted search; a start while busy must not replace it
  logic [REF_W+MUL_W-1:0] tgtSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tgtSeen <= '0;
    else if (start && !busy)  tgtSeen <= targetHz;
  end

  assert_not_above_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    done && !noMatch |-> achievedHz <= tgtSeen);

  assert_exact_hits_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    done && exact |-> achievedHz == tgtSeen);

  assert_nomatch_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    done && noMatch |-> (cfgWord == '0) && (achievedHz == '0) && !exact);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_idle_at_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(cfgWord) && $stable(achievedHz) && $stable(noMatch));

  assert_start_accepted_R9: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

endmodule

bind pll_param_search pllsrch_chk #(
  .REF_W (REF_W),
  .MUL_W (MUL_W),
  .CFG_W (CFG_W)
) u_chk (.*);

// File: tb/test_pll_param_search.sv
module test_pll_param_search;

  localparam int unsigned REF_W = 32;
  localparam int unsigned MUL_W = 8;
  localparam int unsigned TGT_W = REF_W + MUL_W;
  localparam int unsigned NVEC  = 9;
  localparam int unsigned WAIT_LIMIT = 5000;

  // Stimulus table: reference, target, expected class (0 inexact, 1 exact, 2 no match)
  localparam longint unsigned VEC_REF [NVEC] = '{
    64'd25_000_000, 64'd24_000_000, 64'd1000, 64'd100_000_000, 64'd333_000_000,
    64'd50_000_000, 64'd7, 64'd200_000_000, 64'd12_000_000 };
  localparam longint unsigned VEC_TGT [NVEC] = '{
    64'd1_000_000_000, 64'd1_000_000_007, 64'd1000, 64'd10, 64'd85_248_000_000,
    64'd123_456_789, 64'd0, 64'd781_250, 64'd3_071_999_999 };
  localparam int VEC_CLASS [NVEC] = '{1, 0, 1, 2, 1, 0, 1, 1, 0};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [REF_W-1:0] refHz = '0;
  logic [TGT_W-1:0] targetHz = '0;
  logic             busy, done, div1Out, exact, noMatch;
  logic [MUL_W-1:0] mulOut;
  logic [2:0]       div2Out, filtOut;
  logic [TGT_W-1:0] achievedHz;
  logic [31:0]      cfgWord;

  int nChecks = 0;
  int nErrors = 0;
  int cycleCount = 0;

  always #5 clk = ~clk;

  pll_param_search i_pll_param_search (
    .clk(clk), .rstN(rstN), .start(start), .refHz(refHz), .targetHz(targetHz),
    .busy(busy), .done(done), .mulOut(mulOut), .div1Out(div1Out), .div2Out(div2Out),
    .filtOut(filtOut), .achievedHz(achievedHz), .exact(exact), .noMatch(noMatch),
    .cfgWord(cfgWord)
  );

  typedef struct {
    longint unsigned mul, d1, d2, filt, ach, word;
    bit exact, none;
  } expRes_t;

  function automatic longint unsigned filtModel(longint unsigned r, longint unsigned d1);
    longint unsigned f = (r / 1000000) / (d1 + 1);
    if (f >= 166) return 7;
    if (f >= 104) return 6;
    if (f >= 65)  return 5;
    if (f >= 42)  return 4;
    if (f >= 26)  return 3;
    if (f >= 16)  return 2;
    if (f >= 10)  return 1;
    return 0;
  endfunction

  function automatic expRes_t model(longint unsigned r, longint unsigned t);
    expRes_t e;
    bit have = 0;
    longint unsigned bestErr = 0;
    e = '{default: 0};
    for (int d1 = 1; d1 >= 0; d1--) begin
      for (int d2 = 7; d2 >= 0; d2--) begin
        for (int m = 0; m <= 255; m++) begin
          longint unsigned f = (r * longint'(m + 1)) / longint'((d1 + 1) * (1 << d2));
          longint unsigned er;
          if (f > t) continue;
          er = t - f;
          if (!have || er < bestErr) begin
            have = 1; bestErr = er;
            e.mul = m; e.d1 = d1; e.d2 = d2; e.ach = f;
          end
          if (er == 0) begin
            e.exact = 1;
            d1 = -1; d2 = -1; break;
          end
        end
      end
    end
    if (!have) begin
      e.none = 1;
    end else begin
      e.filt = filtModel(r, e.d1);
      e.word = (e.filt << 24) | (e.mul << 16) | (e.d1 << 8) | e.d2;
    end
    return e;
  endfunction

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pulse start for one cycle, then wait for done; returns cycles after the accepting edge
  task automatic runSearch(input longint unsigned r, input longint unsigned t, output int cycles);
    @(negedge clk);
    refHz = REF_W'(r); targetHz = TGT_W'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (!done && cycles < WAIT_LIMIT) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic checkResult(input string tag, input expRes_t e);
    check({tag, " R1/R3"}, "mul", longint'(mulOut), e.mul);
    check({tag, " R3"}, "div1", longint'(div1Out), e.d1);
    check({tag, " R3"}, "div2", longint'(div2Out), e.d2);
    check({tag, " R1 R2"}, "achieved", longint'(achievedHz), e.ach);
    check({tag, " R4"}, "exact", longint'(exact), longint'(e.exact));
    check({tag, " R5"}, "filter", longint'(filtOut), e.filt);
    check({tag, " R6"}, "cfgWord", longint'(cfgWord), e.word);
    check({tag, " R7"}, "noMatch", longint'(noMatch), longint'(e.none));
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount >= 150000) begin
      nErrors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycleCount);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    int cyc;
    expRes_t e;
    int doneSeen;
    logic [31:0] heldWord;

    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", "busy", longint'(busy), 0);
    check("R10", "done", longint'(done), 0);
    check("R10", "cfgWord", longint'(cfgWord), 0);
    check("R10", "noMatch", longint'(noMatch), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "exact after release", longint'(exact), 0);
    check("R10", "mul after release", longint'(mulOut), 0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      e = model(VEC_REF[v], VEC_TGT[v]);
      check("R11", "model class", (e.none ? 2 : (e.exact ? 1 : 0)), longint'(VEC_CLASS[v]));
      runSearch(VEC_REF[v], VEC_TGT[v], cyc);
      check("R8", "done seen", longint'(done), 1);
      check("R11", "cycle bound", longint'(cyc <= 4097), 1);
      checkResult($sformatf("vec%0d", v), e);
      heldWord = cfgWord;
      @(negedge clk);
      check("R8", "done width", longint'(done), 0);
      check("R8", "word held", longint'(cfgWord), longint'(heldWord));
    end

    // R11: exact on the first candidate -> done 2 cycles after the accepting edge
    runSearch(64'd7, 64'd0, cyc);
    check("R11", "first-candidate latency", longint'(cyc), 2);

    // R4/R11: exact hit coincides with the last candidate of the ordering
    e = model(64'd333_000_000, 64'd85_248_000_000);
    runSearch(64'd333_000_000, 64'd85_248_000_000, cyc);
    check("R11", "full-scan latency", longint'(cyc), 4097);
    check("R4", "last-candidate exact", longint'(exact), 1);
    check("R3", "last-candidate mul", longint'(mulOut), 255);
    checkResult("coincide", e);

    // R3: tie among exact settings keeps the earliest (div1=1, div2=7, mul=255)
    runSearch(64'd1000, 64'd1000, cyc);
    check("R3", "tie div1", longint'(div1Out), 1);
    check("R3", "tie div2", longint'(div2Out), 7);
    check("R3", "tie mul", longint'(mulOut), 255);

    // R9: start while busy is ignored
    e = model(64'd24_000_000, 64'd1_000_000_007);
    @(negedge clk);
    refHz = 32'd24_000_000; targetHz = TGT_W'(64'd1_000_000_007); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check("R9", "busy before extra start", longint'(busy), 1);
    refHz = 32'd25_000_000; targetHz = TGT_W'(64'd1_000_000_000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < WAIT_LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    checkResult("R9", e);
    doneSeen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done || busy) doneSeen++;
    end
    check("R9", "no extra search", longint'(doneSeen), 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule